// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter

This block decides which of four DMA channels is allowed onto the system bus. Each channel may ask for service through a hardware request line or through a bit that software writes into a request register. A per-channel mask, set in full by reset, blocks a channel's requests until software clears its bit. Among the unmasked requests, the arbiter picks one winner. The order is either fixed or rotating, and a command bit chooses between the two.

Before any channel is granted, the arbiter asks the bus master for the bus with a hold request and waits for the hold acknowledge. On the acknowledge edge it picks the winner and drives that channel's acknowledge line. It also presents the channel index. Both stay in place until a done pulse reports that the service has ended. If the done pulse carries a terminal-count flag, the serviced channel's software request bit clears itself. A second command bit sets the active level of the request lines, and a third sets the active level of the acknowledge lines.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset, hold request is low. All four mask bits are set, the software request bits are clear and the command register is zero, so every acknowledge line sits at its inactive level (high). No request, hardware or software, raises hold request until its mask bit is cleared.
- R2: A channel whose mask bit is 1 is never granted and does not by itself raise hold request. This holds for both hardware and software requests.
- R3: A channel's effective request is its hardware line at the active level OR its software request bit. The hardware line is active high when command bit 1 is 0 and active low when command bit 1 is 1.
- R4: With command bit 0 clear (fixed order), the lowest-numbered pending channel wins.
- R5: Hold request rises in the cycle after an unmasked request is seen while idle. No acknowledge is driven until hold acknowledge is sampled high. The winner is chosen from the requests pending at that edge. If none is pending then, hold request drops and no channel is granted.
- R6: With command bit 0 set (rotating order), the search starts at the channel after the one last serviced and wraps around, so the serviced channel becomes the lowest. After reset the last-serviced channel is 3.
- R7: While a channel is granted, only its acknowledge line is active. The active level is high when command bit 2 is 1 and low when it is 0. The active-channel index and valid flag are held steady. When done is sampled, the acknowledge and hold request both drop in the next cycle.
- R8: When done is sampled with the terminal-count flag set, the serviced channel's software request bit is cleared. Without the flag, the bit is kept.
- R9: If a request-register write and a terminal-count clear land in the same cycle, the serviced channel's bit ends up clear. The other bits take the written value.
- R10: A register write with select 0 loads the mask from data bits 3:0 (1 = masked). Select 1 loads the software request bits from data bits 3:0. Select 2 loads the command from data bits 2:0. Each write takes effect from the next cycle, and a mask write does not disturb a grant already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dreq_i | input | 4 | Hardware request lines, level set by the command register |
| hlda_i | input | 1 | Hold acknowledge from the bus master |
| done_i | input | 1 | Service of the granted channel has ended |
| tc_i | input | 1 | Terminal count reached, qualified by done_i |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 mask, 1 software request, 2 command |
| reg_wdata_i | input | 4 | Register write data |
| hrq_o | output | 1 | Hold request to the bus master |
| dack_o | output | 4 | Per-channel acknowledge, level set by the command register |
| act_ch_o | output | 2 | Index of the granted channel, 0 when none |
| act_vld_o | output | 1 | A channel is granted |

## Verification
Two functions can act in the same cycle: a software request-register write, and the terminal-count self-clear of the channel being serviced. The bench provokes the overlap by raising the register write in the very cycle that done and terminal count are presented. It then judges the outcome at the ports: the channel named only by the write must be serviced next, and the cleared channel must not raise hold request again. A second overlap comes from a mask write during an active grant; the bench checks that the acknowledge stays held until done.

// File: rtl/dma_arb_pkg.sv
// Shared definitions for the DMA request arbiter: controller states,
// register select codes and command bit positions.
package dma_arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_SERVE = 2'd2
    } arb_state_e;

    localparam logic [1:0] SEL_MASK  = 2'd0;
    localparam logic [1:0] SEL_SWREQ = 2'd1;
    localparam logic [1:0] SEL_CMD   = 2'd2;

    localparam int CMD_W        = 3;
    localparam int CMD_ROTATE   = 0;
    localparam int CMD_REQ_LOW  = 1;
    localparam int CMD_ACK_HIGH = 2;

endpackage

// File: rtl/dma_arb_regs.sv
// Mask, software request and command registers.
// Assumes DATA_W >= N_CH and DATA_W >= CMD_W. A terminal-count clear
// takes precedence over a software request write for the same bit.
module dma_arb_regs
    import dma_arb_pkg::*;
#(
    parameter int N_CH   = 4,
    parameter int CH_W   = 2,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [1:0]        sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              clr_vld_i,
    input  logic [CH_W-1:0]   clr_ch_i,
    output logic [N_CH-1:0]   mask_o,
    output logic [N_CH-1:0]   swreq_o,
    output logic [CMD_W-1:0]  cmd_o
);

    logic [N_CH-1:0] clr_vec;
    logic [N_CH-1:0] sw_next;

    // Decode the terminal-count clear into a channel vector.
    always_comb begin
        clr_vec = '0;
        if (clr_vld_i) begin
            clr_vec = N_CH'(1) << clr_ch_i;
        end
    end

    // Next software request bits: write first, then the clear wins.
    always_comb begin
        sw_next = swreq_o;
        if (wr_i && (sel_i == SEL_SWREQ)) begin
            sw_next = wdata_i[N_CH-1:0];
        end
        sw_next = sw_next & ~clr_vec;
    end

    // Register storage with reset values: all masked, no requests, command zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_o  <= '1;
            swreq_o <= '0;
            cmd_o   <= '0;
        end else begin
            swreq_o <= sw_next;
            if (wr_i && (sel_i == SEL_MASK)) begin
                mask_o <= wdata_i[N_CH-1:0];
            end
            if (wr_i && (sel_i == SEL_CMD)) begin
                cmd_o <= wdata_i[CMD_W-1:0];
            end
        end
    end

endmodule

// File: rtl/dma_arb_prio.sv
// Combinational priority picker. In fixed mode, channel 0 wins first.
// In rotating mode, the scan starts one past last_i and wraps.
// Assumes N_CH is a power of two, so index arithmetic wraps in CH_W bits.
module dma_arb_prio #(
    parameter int N_CH = 4,
    parameter int CH_W = 2
) (
    input  logic [N_CH-1:0] req_i,
    input  logic            rotate_i,
    input  logic [CH_W-1:0] last_i,
    output logic            any_o,
    output logic [CH_W-1:0] win_o
);

    logic [CH_W-1:0] scan_idx;

    // Walk the channels in priority order and keep the first pending one.
    always_comb begin
        any_o    = 1'b0;
        win_o    = '0;
        scan_idx = '0;
        for (int i = 0; i < N_CH; i++) begin
            scan_idx = rotate_i ? (last_i + CH_W'(i + 1)) : CH_W'(i);
            if (!any_o && req_i[scan_idx]) begin
                any_o = 1'b1;
                win_o = scan_idx;
            end
        end
    end

endmodule

// File: rtl/dma_arb_ctrl.sv
// Hold handshake controller. It raises hold on a pending request,
// latches the winner when hold acknowledge is seen, and keeps the grant
// until done. It records the last serviced channel for rotation.
// Assumes done_i only matters while a channel is granted.
module dma_arb_ctrl
    import dma_arb_pkg::*;
#(
    parameter int N_CH = 4,
    parameter int CH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_any_i,
    input  logic [CH_W-1:0] win_ch_i,
    input  logic            hlda_i,
    input  logic            done_i,
    input  logic            tc_i,
    output logic            hold_o,
    output logic            serve_o,
    output logic [CH_W-1:0] grant_o,
    output logic [CH_W-1:0] last_o,
    output logic            clr_vld_o,
    output logic [CH_W-1:0] clr_ch_o
);

    localparam logic [CH_W-1:0] LAST_RST = CH_W'(N_CH - 1);

    arb_state_e state_q, state_d;
    logic [CH_W-1:0] grant_d;
    logic [CH_W-1:0] last_d;

    // Next-state decision for the handshake.
    always_comb begin
        state_d = state_q;
        grant_d = grant_o;
        last_d  = last_o;
        unique case (state_q)
            ST_IDLE: begin
                if (req_any_i) begin
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (hlda_i) begin
                    if (req_any_i) begin
                        state_d = ST_SERVE;
                        grant_d = win_ch_i;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_SERVE: begin
                if (done_i) begin
                    state_d = ST_IDLE;
                    last_d  = grant_o;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, grant and rotation pointer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            grant_o <= '0;
            last_o  <= LAST_RST;
        end else begin
            state_q <= state_d;
            grant_o <= grant_d;
            last_o  <= last_d;
        end
    end

    // Status decode and the terminal-count clear request.
    always_comb begin
        hold_o    = (state_q != ST_IDLE);
        serve_o   = (state_q == ST_SERVE);
        clr_vld_o = serve_o && done_i && tc_i;
        clr_ch_o  = grant_o;
    end

endmodule

// File: rtl/dma_req_arbiter.sv
// Top of the four-channel DMA request arbiter. It merges hardware and
// software requests, applies the mask, and picks a winner. It runs the
// hold handshake and drives the per-channel acknowledge lines at the
// level the command register selects.
// Assumes N_CH is a power of two and DATA_W >= max(N_CH, 3).
module dma_req_arbiter
    import dma_arb_pkg::*;
#(
    parameter int N_CH   = 4,
    parameter int DATA_W = 4,
    localparam int CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CH-1:0]   dreq_i,
    input  logic              hlda_i,
    input  logic              done_i,
    input  logic              tc_i,
    input  logic              reg_wr_i,
    input  logic [1:0]        reg_sel_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic              hrq_o,
    output logic [N_CH-1:0]   dack_o,
    output logic [CH_W-1:0]   act_ch_o,
    output logic              act_vld_o
);

    logic [N_CH-1:0]  mask_q;
    logic [N_CH-1:0]  swreq_q;
    logic [CMD_W-1:0] cmd_q;
    logic [N_CH-1:0]  hw_act;
    logic [N_CH-1:0]  req_eff;
    logic             req_any;
    logic [CH_W-1:0]  win_ch;
    logic             serve;
    logic [CH_W-1:0]  grant_ch;
    logic [CH_W-1:0]  last_ch;
    logic             clr_vld;
    logic [CH_W-1:0]  clr_ch;

    dma_arb_regs #(
        .N_CH   (N_CH),
        .CH_W   (CH_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (reg_wr_i),
        .sel_i     (reg_sel_i),
        .wdata_i   (reg_wdata_i),
        .clr_vld_i (clr_vld),
        .clr_ch_i  (clr_ch),
        .mask_o    (mask_q),
        .swreq_o   (swreq_q),
        .cmd_o     (cmd_q)
    );

    // Normalise the request level, merge software requests, apply the mask.
    always_comb begin
        hw_act  = cmd_q[CMD_REQ_LOW] ? ~dreq_i : dreq_i;
        req_eff = (hw_act | swreq_q) & ~mask_q;
    end

    dma_arb_prio #(
        .N_CH (N_CH),
        .CH_W (CH_W)
    ) u_prio (
        .req_i    (req_eff),
        .rotate_i (cmd_q[CMD_ROTATE]),
        .last_i   (last_ch),
        .any_o    (req_any),
        .win_o    (win_ch)
    );

    dma_arb_ctrl #(
        .N_CH (N_CH),
        .CH_W (CH_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_any_i (req_any),
        .win_ch_i  (win_ch),
        .hlda_i    (hlda_i),
        .done_i    (done_i),
        .tc_i      (tc_i),
        .hold_o    (hrq_o),
        .serve_o   (serve),
        .grant_o   (grant_ch),
        .last_o    (last_ch),
        .clr_vld_o (clr_vld),
        .clr_ch_o  (clr_ch)
    );

    // Per-channel acknowledge with the selected active level.
    for (genvar g = 0; g < N_CH; g++) begin : g_dack
        logic ack_on;
        assign ack_on    = serve && (grant_ch == CH_W'(g));
        assign dack_o[g] = cmd_q[CMD_ACK_HIGH] ? ack_on : ~ack_on;
    end

    // Active channel reporting; index reads zero when idle.
    always_comb begin
        act_vld_o = serve;
        act_ch_o  = serve ? grant_ch : '0;
    end

endmodule

// File: rtl/dma_arb_checker.sv
// Property checker for the DMA request arbiter, bound into the top.
// It watches the ports and the register outputs only.
module dma_arb_checker
    import dma_arb_pkg::*;
#(
    parameter int N_CH = 4,
    parameter int CH_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hlda_i,
    input logic             done_i,
    input logic             tc_i,
    input logic             hrq_o,
    input logic [N_CH-1:0]  dack_o,
    input logic [CH_W-1:0]  act_ch_o,
    input logic             act_vld_o,
    input logic [N_CH-1:0]  mask_q,
    input logic [N_CH-1:0]  swreq_q,
    input logic [CMD_W-1:0] cmd_q
);

    logic [N_CH-1:0] ack_act;
    assign ack_act = cmd_q[CMD_ACK_HIGH] ? dack_o : ~dack_o;

    AST_RESET_MASKED: assert property (@(posedge clk)
        (!rst_n) |=> (mask_q == '1 && !hrq_o)); // R1

    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_act)); // R7

    AST_ACK_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_act != '0) |-> hrq_o); // R5

    AST_GRANT_AFTER_HLDA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_vld_o) |-> $past(hlda_i)); // R5

    AST_GRANT_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_vld_o) |-> (($past(mask_q) & (N_CH'(1) << act_ch_o)) == '0)); // R2

    AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (act_vld_o && !done_i) |=> (act_vld_o && $stable(act_ch_o))); // R7

    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (act_vld_o && done_i) |=> (!act_vld_o && !hrq_o)); // R7

    AST_TC_CLEARS_SW: assert property (@(posedge clk) disable iff (!rst_n)
        (act_vld_o && done_i && tc_i) |=> ((swreq_q & (N_CH'(1) << $past(act_ch_o))) == '0)); // R8

endmodule

bind dma_req_arbiter dma_arb_checker #(
    .N_CH (N_CH),
    .CH_W (CH_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hlda_i    (hlda_i),
    .done_i    (done_i),
    .tc_i      (tc_i),
    .hrq_o     (hrq_o),
    .dack_o    (dack_o),
    .act_ch_o  (act_ch_o),
    .act_vld_o (act_vld_o),
    .mask_q    (mask_q),
    .swreq_q   (swreq_q),
    .cmd_q     (cmd_q)
);

// File: tb/dma_req_arbiter_bench.sv
`timescale 1ns/1ps
module dma_req_arbiter_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] dreq = '0;
    logic       hlda = 1'b0;
    logic       done = 1'b0;
    logic       tc = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_sel = '0;
    logic [3:0] reg_wdata = '0;
    logic       hrq;
    logic [3:0] dack;
    logic [1:0] act_ch;
    logic       act_vld;

    int checks = 0;
    int failures = 0;
    int cyc_cnt = 0;

    always #2.5 clk = ~clk;

    dma_req_arbiter u_dma_req_arbiter (
        .clk         (clk),
        .rst_n       (rst_n),
        .dreq_i      (dreq),
        .hlda_i      (hlda),
        .done_i      (done),
        .tc_i        (tc),
        .reg_wr_i    (reg_wr),
        .reg_sel_i   (reg_sel),
        .reg_wdata_i (reg_wdata),
        .hrq_o       (hrq),
        .dack_o      (dack),
        .act_ch_o    (act_ch),
        .act_vld_o   (act_vld)
    );

    // Behavioural reference model
    int       m_st = 0;      // 0 idle, 1 holding, 2 serving
    bit [3:0] m_mask = 4'hF;
    bit [3:0] m_sw = '0;
    bit [2:0] m_cmd = '0;
    int       m_last = 3;
    int       m_grant = 0;

    function automatic int m_pick(bit [3:0] r);
        for (int i = 0; i < 4; i++) begin
            int c;
            c = m_cmd[0] ? (m_last + 1 + i) % 4 : i;
            if (r[c]) return c;
        end
        return -1;
    endfunction

    always @(posedge clk) begin
        int n_st, n_grant, n_last, pk;
        bit [3:0] hw, r, n_mask, n_sw, clr;
        bit [2:0] n_cmd;
        if (!rst_n) begin
            m_st = 0; m_mask = 4'hF; m_sw = '0; m_cmd = '0; m_last = 3; m_grant = 0;
        end else begin
            hw = m_cmd[1] ? ~dreq : dreq;
            r = (hw | m_sw) & ~m_mask;
            pk = m_pick(r);
            n_st = m_st; n_grant = m_grant; n_last = m_last; clr = '0;
            if (m_st == 0) begin
                if (pk >= 0) n_st = 1;
            end else if (m_st == 1) begin
                if (hlda) begin
                    if (pk >= 0) begin n_st = 2; n_grant = pk; end
                    else n_st = 0;
                end
            end else if (done) begin
                n_st = 0; n_last = m_grant;
                if (tc) clr[m_grant] = 1'b1;
            end
            n_mask = m_mask; n_sw = m_sw; n_cmd = m_cmd;
            if (reg_wr) begin
                if (reg_sel == 2'd0) n_mask = reg_wdata;
                else if (reg_sel == 2'd1) n_sw = reg_wdata;
                else if (reg_sel == 2'd2) n_cmd = reg_wdata[2:0];
            end
            n_sw = n_sw & ~clr;
            m_st = n_st; m_grant = n_grant; m_last = n_last;
            m_mask = n_mask; m_sw = n_sw; m_cmd = n_cmd;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Compare against the model every cycle, mid-period.
    always @(negedge clk) begin
        if (rst_n) begin
            bit [3:0] e_dack;
            for (int c = 0; c < 4; c++) begin
                bit a;
                a = (m_st == 2) && (m_grant == c);
                e_dack[c] = m_cmd[2] ? a : !a;
            end
            chk("R5 hrq_o model", 32'(hrq), 32'(m_st != 0));
            chk("R7 dack_o model", 32'(dack), 32'(e_dack));
            chk("R7 act_vld_o model", 32'(act_vld), 32'(m_st == 2));
            chk("R4 R6 act_ch_o model", 32'(act_ch), (m_st == 2) ? 32'(m_grant) : 32'd0);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 20000) begin
            failures++;
            $display("FAIL R5 watchdog actual=%0d expected=finish", cyc_cnt);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [1:0] s, logic [3:0] d);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        cyc();
        reg_wr = 1'b0;
    endtask

    task automatic wait_hrq(string rq);
        int n = 0;
        while (!hrq && n < 20) begin cyc(); n++; end
        chk({rq, " hold request raised"}, 32'(hrq), 32'd1);
    endtask

    task automatic serve(string rq, int exp_ch, bit with_tc);
        wait_hrq(rq);
        hlda = 1'b1;
        cyc();
        chk({rq, " granted"}, 32'(act_vld), 32'd1);
        chk({rq, " winner"}, 32'(act_ch), 32'(exp_ch));
        cyc();
        chk({rq, " grant held"}, 32'(act_vld), 32'd1);
        done = 1'b1; tc = with_tc;
        cyc();
        done = 1'b0; tc = 1'b0;
        chk("R7 hold dropped after done", 32'(hrq), 32'd0);
        hlda = 1'b0;
        cyc();
    endtask

    initial begin
        repeat (4) cyc();
        rst_n = 1'b1;
        cyc();
        chk("R1 hrq after reset", 32'(hrq), 32'd0);
        chk("R1 dack after reset", 32'(dack), 32'hF);
        chk("R1 act_vld after reset", 32'(act_vld), 32'd0);
        dreq = 4'hF;
        repeat (5) cyc();
        chk("R2 masked requests ignored", 32'(hrq), 32'd0);
        dreq = '0;
        wr(2'd0, 4'h0);

        // R4 fixed order
        dreq = 4'b1010;
        serve("R4", 1, 1'b0);
        serve("R4", 1, 1'b0);

        // R2 mask one channel
        wr(2'd0, 4'b0010);
        serve("R2", 3, 1'b0);

        // R3 active-low requests
        wr(2'd0, 4'hF);
        dreq = 4'b1011;
        wr(2'd2, 4'b0010);
        wr(2'd0, 4'h0);
        serve("R3", 2, 1'b0);

        // R7 active-high acknowledge
        wr(2'd0, 4'hF);
        wr(2'd2, 4'b0110);
        wr(2'd0, 4'h0);
        wait_hrq("R5");
        chk("R5 no ack before hlda", 32'(dack), 32'h0);
        hlda = 1'b1;
        cyc();
        chk("R7 active-high ack", 32'(dack), 32'b0100);
        done = 1'b1;
        cyc();
        done = 1'b0;
        chk("R7 ack released", 32'(dack), 32'h0);
        hlda = 1'b0;
        cyc();

        // R6 rotating order after channel 2 was serviced
        wr(2'd0, 4'hF);
        dreq = 4'hF;
        wr(2'd2, 4'b0001);
        wr(2'd0, 4'h0);
        serve("R6", 3, 1'b0);
        serve("R6", 0, 1'b0);
        serve("R6", 1, 1'b0);
        serve("R6", 2, 1'b0);

        // R5 request withdrawn before hold acknowledge
        wr(2'd0, 4'hF);
        dreq = '0;
        wr(2'd2, 4'b0000);
        wr(2'd0, 4'h0);
        dreq = 4'b0001;
        wait_hrq("R5");
        dreq = '0;
        cyc();
        chk("R5 no grant while waiting", 32'(act_vld), 32'd0);
        hlda = 1'b1;
        cyc();
        chk("R5 no grant without request", 32'(act_vld), 32'd0);
        chk("R5 hold dropped without request", 32'(hrq), 32'd0);
        hlda = 1'b0;
        cyc();

        // R8 software request and terminal count
        wr(2'd1, 4'b0100);
        serve("R8", 2, 1'b0);
        serve("R8", 2, 1'b1);
        repeat (3) cyc();
        chk("R8 software bit cleared", 32'(hrq), 32'd0);

        // R9 write and clear in the same cycle
        wr(2'd1, 4'b0010);
        wait_hrq("R9");
        hlda = 1'b1;
        cyc();
        chk("R9 winner", 32'(act_ch), 32'd1);
        done = 1'b1; tc = 1'b1;
        reg_wr = 1'b1; reg_sel = 2'd1; reg_wdata = 4'b0011;
        cyc();
        done = 1'b0; tc = 1'b0; reg_wr = 1'b0;
        hlda = 1'b0;
        cyc();
        serve("R9", 0, 1'b1);
        repeat (3) cyc();
        chk("R9 serviced bit stayed clear", 32'(hrq), 32'd0);

        // R10 mask write during an active grant
        wr(2'd1, 4'b0001);
        wait_hrq("R10");
        hlda = 1'b1;
        cyc();
        chk("R10 winner", 32'(act_ch), 32'd0);
        wr(2'd0, 4'hF);
        chk("R10 grant kept after mask write", 32'(act_vld), 32'd1);
        cyc();
        chk("R10 grant still kept", 32'(act_vld), 32'd1);
        done = 1'b1;
        cyc();
        done = 1'b0;
        hlda = 1'b0;
        chk("R10 hold dropped", 32'(hrq), 32'd0);
        repeat (3) cyc();
        chk("R10 masked software request idle", 32'(hrq), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule